// File: doc/BRIEF.md
# Configurable Performance Event Counter

A single performance-monitoring counter for use inside a larger monitoring fabric. A small set of control pins picks the increment source: one bit of an external event vector, a status pulse from a partner counter, or every clock. The chosen signal can be inverted, and is then counted in one of four modes: level (every cycle it is high), rising edge, latch-then-count-clocks, or queue-occupancy accumulation. In the last mode the counter adds the queue value bus on a push and subtracts it on a pop. This builds a running occupancy integral of a FIFO.

All control inputs are plain pins, held by whatever register block owns them; decoding of that register block is not part of this design. The push, pop and queue value inputs are observed strobes taken from a FIFO that the counter only watches. They carry no valid/ready pair because the counter never applies back-pressure: it samples them every enabled cycle and can never stall the queue it measures.

Top module: `perf_event_counter`

## Requirements
- R1: Source select `src_sel` encodes 2'b00 as bit `evt_idx` of `evt_vec`, 2'b01 as `partner_stat`, and 2'b10 as a constant 1. 2'b11 is reserved: while it is selected the counter holds its value in every mode, whatever the invert bit says.
- R2: When `invert` is 1 the selected source is inverted before the count-mode logic sees it. When `invert` is 0 the source passes unchanged.
- R3: With `mode` 2'b00 (level), the counter rises by exactly one on every enabled clock for which the conditioned event is 1.
- R4: With `mode` 2'b01 (edge), the counter rises by one in each enabled cycle where the conditioned event is 1 and its registered previous value is 0. That previous value resets to 0, so an event already high at enable counts once.
- R5: With `mode` 2'b10 (latch), the counter rises by one in the cycle the conditioned event is first 1 and in every enabled cycle after that. A `clr_latch` cycle clears the latch and suppresses that cycle's increment. `cnt_rst`, `glob_rst` and `rst_n` also clear the latch.
- R6: With `mode` 2'b11 (queue accumulation), a cycle with push only adds the zero-extended `q_val`, and a cycle with pop only subtracts it. A cycle with both or neither leaves the count unchanged. Subtraction below zero wraps modulo 2^CNT_W and does not set `ovf`.
- R7: Queue accumulation starts only in the cycle after `q_empty` was seen high while enabled in mode 2'b11. That start condition is latched. `clr_latch` does not clear it; only `cnt_rst`, `glob_rst` or `rst_n` clear it.
- R8: An addition that carries past the counter maximum wraps the count and sets `ovf`. `ovf` then stays set until a counter reset.
- R9: While `glb_en` is 0, the count, the overflow flag, the edge history and the set of any latch are frozen.
- R10: `cnt_rst` and `glob_rst` each clear the count, `ovf`, the edge history and both latches on the next edge, with priority over any increment in that cycle, whether or not `glb_en` is high. `rst_n` low does the same asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en | input | 1 | Global count enable |
| evt_vec | input | NUM_EVT | External event vector |
| evt_idx | input | EVT_SEL_W | Index of the event bit used by source 2'b00 |
| src_sel | input | 2 | Increment source select |
| invert | input | 1 | Invert the selected source |
| mode | input | 2 | Count mode: level, edge, latch, queue |
| partner_stat | input | 1 | Status pulse from the partner counter |
| q_push | input | 1 | Queue push strobe |
| q_pop | input | 1 | Queue pop strobe |
| q_val | input | QVAL_W | Queue value added or subtracted |
| q_empty | input | 1 | Queue empty indication |
| cnt_rst | input | 1 | Counter reset for this counter |
| glob_rst | input | 1 | Global reset of all counters |
| clr_latch | input | 1 | Clear the event latch of mode 2'b10 |
| count | output | CNT_W | Counter value |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The bench builds the counter with CNT_W=8, NUM_EVT=4 and QVAL_W=4 rather than the 48-bit default. With an 8-bit counter, the carry past the maximum, the wrap to zero and the sticky flag are reached in a few hundred cycles, both by counting clocks and by a queue push. The narrow queue value lets a pop larger than the count drive it below zero, which exercises wraparound without the flag. Four event bits are enough to show that the index selects one bit and ignores its neighbours.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [1:0] {
    SRC_EVENT   = 2'b00,
    SRC_PARTNER = 2'b01,
    SRC_ALWAYS  = 2'b10,
    SRC_RSVD    = 2'b11
  } src_sel_e;

  typedef enum logic [1:0] {
    MODE_LEVEL = 2'b00,
    MODE_EDGE  = 2'b01,
    MODE_LATCH = 2'b10,
    MODE_QUEUE = 2'b11
  } cnt_mode_e;

endpackage

// File: rtl/pmc_event_cond.sv
module pmc_event_cond
  import pmc_pkg::*;
#(
  parameter int NUM_EVT = 8,
  parameter int SEL_W   = 3
) (
  input  logic [NUM_EVT-1:0] evt_vec,
  input  logic [SEL_W-1:0]   evt_idx,
  input  src_sel_e           src_sel,
  input  logic               partner_stat,
  input  logic               invert,
  output logic               cond_evt,
  output logic               src_ok
);

  logic picked_bit;
  logic raw_src;

  // Pick one event bit; an index past the vector reads as 0.
  always_comb begin
    picked_bit = 1'b0;
    for (int i = 0; i < NUM_EVT; i++) begin
      if (evt_idx == SEL_W'(i)) picked_bit = evt_vec[i];
    end
  end

  always_comb begin
    raw_src = 1'b0;
    src_ok  = 1'b1;
    unique case (src_sel)
      SRC_EVENT:   raw_src = picked_bit;
      SRC_PARTNER: raw_src = partner_stat;
      SRC_ALWAYS:  raw_src = 1'b1;
      default: begin
        raw_src = 1'b0;
        src_ok  = 1'b0;
      end
    endcase
  end

  assign cond_evt = raw_src ^ invert;

endmodule

// File: rtl/pmc_mode_ctrl.sv
module pmc_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int CNT_W  = 48,
  parameter int QVAL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              clr_all,
  input  logic              clr_latch,
  input  cnt_mode_e         mode,
  input  logic              cond_evt,
  input  logic              src_ok,
  input  logic              q_push,
  input  logic              q_pop,
  input  logic [QVAL_W-1:0] q_val,
  input  logic              q_empty,
  output logic              step_go,
  output logic              step_sub,
  output logic [CNT_W-1:0]  step_val
);

  logic prev_evt;
  logic evt_latch;
  logic empty_seen;

  // Previous conditioned event for rising-edge detection.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prev_evt <= 1'b0;
    else if (clr_all) prev_evt <= 1'b0;
    else if (en)      prev_evt <= cond_evt;
  end

  // Event latch of the latch-then-count mode.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         evt_latch <= 1'b0;
    else if (clr_all)   evt_latch <= 1'b0;
    else if (clr_latch) evt_latch <= 1'b0;
    else if (en && src_ok && mode == MODE_LATCH && cond_evt)
      evt_latch <= 1'b1;
  end

  // Queue-empty start condition; clr_latch has no effect on it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       empty_seen <= 1'b0;
    else if (clr_all) empty_seen <= 1'b0;
    else if (en && mode == MODE_QUEUE && q_empty)
      empty_seen <= 1'b1;
  end

  always_comb begin
    step_go  = 1'b0;
    step_sub = 1'b0;
    step_val = '0;
    if (en && src_ok) begin
      unique case (mode)
        MODE_LEVEL: begin
          step_go  = cond_evt;
          step_val = CNT_W'(1);
        end
        MODE_EDGE: begin
          step_go  = cond_evt && !prev_evt;
          step_val = CNT_W'(1);
        end
        MODE_LATCH: begin
          step_go  = !clr_latch && (evt_latch || cond_evt);
          step_val = CNT_W'(1);
        end
        default: begin
          step_go  = empty_seen && (q_push ^ q_pop);
          step_sub = q_pop;
          step_val = CNT_W'(q_val);
        end
      endcase
    end
  end

  // R7
  queue_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_QUEUE && !empty_seen) |-> !step_go);

  // R3
  unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_go && mode != MODE_QUEUE) |-> (step_val == CNT_W'(1) && !step_sub));

  // R7
  start_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_seen && !clr_all) |=> empty_seen);

endmodule

// File: rtl/pmc_accum.sv
module pmc_accum #(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic             step_go,
  input  logic             step_sub,
  input  logic [CNT_W-1:0] step_val,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);

  logic [CNT_W:0]   sum_ext;
  logic [CNT_W-1:0] diff;

  assign sum_ext = {1'b0, count} + {1'b0, step_val};
  assign diff    = count - step_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (clr_all) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (step_go) begin
      if (step_sub) begin
        count <= diff;
      end else begin
        count <= sum_ext[CNT_W-1:0];
        ovf   <= ovf | sum_ext[CNT_W];
      end
    end
  end

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr_all) |=> ovf);

  // R6
  sub_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_go && step_sub && !ovf && !clr_all) |=> !ovf);

endmodule

// File: rtl/perf_event_counter.sv
module perf_event_counter
  import pmc_pkg::*;
#(
  parameter int  CNT_W     = 48,
  parameter int  NUM_EVT   = 8,
  parameter int  QVAL_W    = 8,
  localparam int EVT_SEL_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 glb_en,
  input  logic [NUM_EVT-1:0]   evt_vec,
  input  logic [EVT_SEL_W-1:0] evt_idx,
  input  logic [1:0]           src_sel,
  input  logic                 invert,
  input  logic [1:0]           mode,
  input  logic                 partner_stat,
  input  logic                 q_push,
  input  logic                 q_pop,
  input  logic [QVAL_W-1:0]    q_val,
  input  logic                 q_empty,
  input  logic                 cnt_rst,
  input  logic                 glob_rst,
  input  logic                 clr_latch,
  output logic [CNT_W-1:0]     count,
  output logic                 ovf
);

  logic             clr_all;
  logic             cond_evt;
  logic             src_ok;
  logic             step_go;
  logic             step_sub;
  logic [CNT_W-1:0] step_val;

  assign clr_all = cnt_rst | glob_rst;

  pmc_event_cond #(
    .NUM_EVT (NUM_EVT),
    .SEL_W   (EVT_SEL_W)
  ) u_cond (
    .evt_vec      (evt_vec),
    .evt_idx      (evt_idx),
    .src_sel      (src_sel_e'(src_sel)),
    .partner_stat (partner_stat),
    .invert       (invert),
    .cond_evt     (cond_evt),
    .src_ok       (src_ok)
  );

  pmc_mode_ctrl #(
    .CNT_W  (CNT_W),
    .QVAL_W (QVAL_W)
  ) u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (glb_en),
    .clr_all   (clr_all),
    .clr_latch (clr_latch),
    .mode      (cnt_mode_e'(mode)),
    .cond_evt  (cond_evt),
    .src_ok    (src_ok),
    .q_push    (q_push),
    .q_pop     (q_pop),
    .q_val     (q_val),
    .q_empty   (q_empty),
    .step_go   (step_go),
    .step_sub  (step_sub),
    .step_val  (step_val)
  );

  pmc_accum #(
    .CNT_W (CNT_W)
  ) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_all  (clr_all),
    .step_go  (step_go),
    .step_sub (step_sub),
    .step_val (step_val),
    .count    (count),
    .ovf      (ovf)
  );

  // R9
  frozen_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en && !clr_all) |=> (count == $past(count) && ovf == $past(ovf)));

  // R10
  reset_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (count == '0 && !ovf));

  // R1
  reserved_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'b11 && !clr_all) |=> count == $past(count));

endmodule

// File: tb/test_perf_event_counter.sv
module test_perf_event_counter;

  localparam int CNT_W   = 8;
  localparam int NUM_EVT = 4;
  localparam int QVAL_W  = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              glb_en = 1'b0;
  logic [NUM_EVT-1:0] evt_vec = '0;
  logic [1:0]        evt_idx = '0;
  logic [1:0]        src_sel = '0;
  logic              invert = 1'b0;
  logic [1:0]        mode = '0;
  logic              partner_stat = 1'b0;
  logic              q_push = 1'b0;
  logic              q_pop = 1'b0;
  logic [QVAL_W-1:0] q_val = '0;
  logic              q_empty = 1'b0;
  logic              cnt_rst = 1'b0;
  logic              glob_rst = 1'b0;
  logic              clr_latch = 1'b0;
  logic [CNT_W-1:0]  count;
  logic              ovf;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  perf_event_counter #(
    .CNT_W   (CNT_W),
    .NUM_EVT (NUM_EVT),
    .QVAL_W  (QVAL_W)
  ) i_perf_event_counter (
    .clk          (clk),
    .rst_n        (rst_n),
    .glb_en       (glb_en),
    .evt_vec      (evt_vec),
    .evt_idx      (evt_idx),
    .src_sel      (src_sel),
    .invert       (invert),
    .mode         (mode),
    .partner_stat (partner_stat),
    .q_push       (q_push),
    .q_pop        (q_pop),
    .q_val        (q_val),
    .q_empty      (q_empty),
    .cnt_rst      (cnt_rst),
    .glob_rst     (glob_rst),
    .clr_latch    (clr_latch),
    .count        (count),
    .ovf          (ovf)
  );

  // {src, inv, mode, evt_vec, idx, partner, cycles, expected count}
  localparam int VW = 28;
  localparam int NV = 12;
  localparam logic [VW-1:0] VEC [NV] = '{
    {2'b00, 1'b0, 2'b00, 4'b0100, 2'd2, 1'b0, 8'd5, 8'd5},  // R1 R3 event bit
    {2'b00, 1'b0, 2'b00, 4'b0100, 2'd1, 1'b0, 8'd5, 8'd0},  // R1 neighbour bit
    {2'b00, 1'b1, 2'b00, 4'b0100, 2'd1, 1'b0, 8'd5, 8'd5},  // R2 inverted
    {2'b01, 1'b0, 2'b00, 4'b0000, 2'd0, 1'b1, 8'd4, 8'd4},  // R1 partner
    {2'b01, 1'b0, 2'b00, 4'b1111, 2'd0, 1'b0, 8'd4, 8'd0},  // R1 partner low
    {2'b10, 1'b0, 2'b00, 4'b0000, 2'd0, 1'b0, 8'd6, 8'd6},  // R1 every clock
    {2'b10, 1'b1, 2'b00, 4'b0000, 2'd0, 1'b0, 8'd6, 8'd0},  // R2 inverted clock
    {2'b11, 1'b0, 2'b00, 4'b1111, 2'd0, 1'b1, 8'd6, 8'd0},  // R1 reserved
    {2'b11, 1'b1, 2'b00, 4'b0000, 2'd0, 1'b0, 8'd6, 8'd0},  // R1 reserved inverted
    {2'b10, 1'b0, 2'b01, 4'b0000, 2'd0, 1'b0, 8'd6, 8'd1},  // R4 high at enable
    {2'b10, 1'b0, 2'b10, 4'b0000, 2'd0, 1'b0, 8'd5, 8'd5},  // R5 latch counts clocks
    {2'b00, 1'b1, 2'b01, 4'b0001, 2'd0, 1'b0, 8'd6, 8'd0}   // R2 R4 inverted steady high
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_cnt_rst();
    cnt_rst = 1'b1;
    tick();
    cnt_rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog R1..all actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #25;
    // R10 reset state
    check("R10 reset count", count, 0);
    check("R10 reset ovf", ovf, 0);
    rst_n = 1'b1;
    tick();

    // vector table
    for (int v = 0; v < NV; v++) begin
      glb_en = 1'b0;
      pulse_cnt_rst();
      {src_sel, invert, mode, evt_vec, evt_idx, partner_stat} = VEC[v][VW-1:16];
      glb_en = 1'b1;
      for (int c = 0; c < int'(VEC[v][15:8]); c++) tick();
      check($sformatf("R1-table vec%0d count", v), count, int'(VEC[v][7:0]));
    end

    // R4 toggling event: edges at samples 1,4,7
    src_sel = 2'b00; invert = 1'b0; mode = 2'b01; evt_idx = 2'd0; evt_vec = '0;
    pulse_cnt_rst();
    foreach (VEC[k]) begin end
    evt_vec[0] = 1'b1; tick();
    evt_vec[0] = 1'b1; tick();
    evt_vec[0] = 1'b0; tick();
    evt_vec[0] = 1'b1; tick();
    evt_vec[0] = 1'b0; tick();
    evt_vec[0] = 1'b0; tick();
    evt_vec[0] = 1'b1; tick();
    check("R4 rising edges", count, 3);

    // R5 latch mode and its clears
    mode = 2'b10; evt_vec = '0;
    pulse_cnt_rst();
    repeat (3) tick();
    check("R5 idle before event", count, 0);
    evt_vec[0] = 1'b1; tick();
    evt_vec[0] = 1'b0; repeat (4) tick();
    check("R5 counts after pulse", count, 5);
    clr_latch = 1'b1; tick();
    clr_latch = 1'b0;
    check("R5 clr_latch cycle", count, 5);
    repeat (2) tick();
    check("R5 latch cleared", count, 5);
    evt_vec[0] = 1'b1; tick();
    check("R5 relatch", count, 6);
    evt_vec[0] = 1'b0; glob_rst = 1'b1; tick();
    glob_rst = 1'b0;
    check("R10 glob_rst clears", count, 0);
    repeat (3) tick();
    check("R5 R10 glob_rst cleared latch", count, 0);

    // R9 enable low freezes
    src_sel = 2'b10; mode = 2'b00;
    pulse_cnt_rst();
    repeat (3) tick();
    check("R3 three clocks", count, 3);
    glb_en = 1'b0;
    repeat (4) tick();
    check("R9 frozen", count, 3);
    pulse_cnt_rst();
    check("R10 cnt_rst while disabled", count, 0);
    glb_en = 1'b1;

    // R8 overflow through clock counting
    pulse_cnt_rst();
    repeat (255) tick();
    check("R8 at max", count, 255);
    check("R8 no flag at max", ovf, 0);
    tick();
    check("R8 wrap", count, 0);
    check("R8 flag set", ovf, 1);
    tick();
    check("R8 sticky", ovf, 1);

    // R6 R7 queue accumulation
    src_sel = 2'b00; mode = 2'b11; evt_vec = '0;
    pulse_cnt_rst();
    check("R10 cnt_rst clears ovf", ovf, 0);
    q_push = 1'b1; q_val = 4'd5; repeat (2) tick();
    check("R7 no start before empty", count, 0);
    q_empty = 1'b1; tick();
    q_empty = 1'b0;
    check("R7 empty cycle not counted", count, 0);
    tick();
    check("R6 push adds", count, 5);
    q_val = 4'd3; tick();
    check("R6 push adds again", count, 8);
    q_push = 1'b0; q_pop = 1'b1; q_val = 4'd2; tick();
    check("R6 pop subtracts", count, 6);
    q_push = 1'b1; q_val = 4'd7; tick();
    check("R6 push and pop", count, 6);
    q_push = 1'b0; q_pop = 1'b0; tick();
    check("R6 idle", count, 6);
    clr_latch = 1'b1; q_push = 1'b1; q_val = 4'd1; tick();
    clr_latch = 1'b0;
    check("R7 clr_latch keeps start", count, 7);
    q_push = 1'b0; q_pop = 1'b1; q_val = 4'd9; tick();
    check("R6 wrap below zero", count, 254);
    check("R6 no flag on underflow", ovf, 0);
    q_pop = 1'b0; q_push = 1'b1; q_val = 4'd2; tick();
    check("R8 push wraps", count, 0);
    check("R8 push sets flag", ovf, 1);
    q_val = 4'd3; tick();
    check("R8 flag stays", ovf, 1);
    check("R8 keeps counting", count, 3);
    pulse_cnt_rst();
    q_val = 4'd4; repeat (2) tick();
    check("R7 R10 start cleared by cnt_rst", count, 0);
    q_push = 1'b0;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule